// File: doc/BRIEF.md
# Branch Target and Return Stack Sequencer

This block owns the program counter and the stack pointer of a small 8-bit controller with a 16-bit code space. The fetch and decode logic issues one operation per `start` pulse, together with the instruction length, the opcode, up to two operand bytes, the accumulator, the data pointer and a `taken` flag. The block produces the next program counter for sequential flow, relative branches, page-absolute jumps and calls, long jumps and calls, indexed jumps and returns. It also drives the address for table reads that are indexed from the program counter.

Calls and returns use a one-byte-wide internal RAM port. A call writes the return address onto an upward-growing stack, low byte first, and increments the pointer before each write. A return reads it back in the opposite order. The finite-state machine has five named states. ST_IDLE accepts `start`. A call goes ST_IDLE -> ST_PUSH_LO -> ST_PUSH_HI -> ST_IDLE. A return goes ST_IDLE -> ST_POP_HI -> ST_POP_LO -> ST_IDLE. All other operations finish in ST_IDLE in one cycle. `done` pulses in the cycle after each operation completes, and by then the program counter already holds the new value.

Top module: `pc_seq_unit`

## Requirements
- R1: After reset, `pc` is 0000h, `sp` is 07h, `busy` and `done` are low, and no RAM access is made. While idle, `sp` does not change.
- R2: `op_kind` 1 (relative) with `taken` high loads `pc + len + sext(off)`. The offset `off` is `op2` when `instr_len` is 3 and `op1` otherwise. With `taken` low it loads `pc + len`.
- R3: `op_kind` 2 (page form) forms its target from (`pc`+2)[15:11], `opcode`[7:5] as bits 10:8 and `op1` as bits 7:0. When `opcode`[4:0] is 10001b the operation is a call; otherwise it is a jump.
- R4: A call writes RAM[`sp`+1] with the low return byte, then RAM[`sp`+2] with the high return byte, in two consecutive cycles. It leaves `sp` raised by 2 and `pc` at the target. For example, a page call at 0123h with `sp`=07h to 0345h gives RAM[08h]=25h, RAM[09h]=01h, `sp`=09h and `pc`=0345h.
- R5: `op_kind` 3 (long jump) and 4 (long call) use the target {`op1`,`op2`}. The long call pushes the return address `pc`+3.
- R6: `op_kind` 5 (indexed) loads `dptr` plus the zero-extended `acc`.
- R7: `op_kind` 6 (return) reads the high byte from RAM[`sp`], then the low byte from RAM[`sp`-1]. It lowers `sp` by 2 and loads `pc` from the two bytes.
- R8: `op_kind` 7 (interrupt return) behaves like R7 and also raises `irq_done` for exactly the one cycle in which `done` is high. A plain return never raises `irq_done`.
- R9: `tbl_addr` always equals `pc + instr_len + acc`, so index 0 addresses the byte after the table-read instruction.
- R10: A `start` that arrives while `busy` is high has no effect on `pc`, `sp` or `done`.
- R11: `op_kind` 0 (sequential) loads `pc + instr_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue one operation (accepted only when idle) |
| op_kind | input | 3 | Operation code, see R2 to R11 |
| instr_len | input | 2 | Length of the current instruction in bytes |
| opcode | input | 8 | Opcode byte |
| op1 | input | 8 | First operand byte |
| op2 | input | 8 | Second operand byte |
| taken | input | 1 | Branch condition result for relative operations |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| ram_rdata | input | 8 | Read data from internal RAM at `ram_addr`, same cycle |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | A push or pop sequence is in progress |
| done | output | 1 | One-cycle pulse after an operation completes |
| irq_done | output | 1 | One-cycle interrupt-return completion pulse |
| tbl_addr | output | 16 | Program-counter-relative table read address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |

## Verification
A wrong sequencer state shows at the RAM port within one or two cycles. The symptoms are a write strobe lasting one cycle instead of two, bytes landing in the wrong order or at an unincremented address, or `sp` moving while idle. A wrong target shows in `pc` at the first `done` pulse after the operation. A corrupted push appears only later, when the matching return loads a wrong `pc`, so the bench always pairs each call with a return and also checks the stacked bytes directly.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        OP_SEQ   = 3'd0,
        OP_REL   = 3'd1,
        OP_PAGE  = 3'd2,
        OP_LJMP  = 3'd3,
        OP_LCALL = 3'd4,
        OP_IDX   = 3'd5,
        OP_RET   = 3'd6,
        OP_RETI  = 3'd7
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_POP_HI,
        ST_POP_LO
    } seq_state_e;

    localparam logic [4:0] PAGE_CALL_LOW5 = 5'b10001;

endpackage

// File: rtl/pcs_target_calc.sv
module pcs_target_calc #(
    parameter int PC_W = 16,
    parameter int DW   = 8
) (
    input  logic [PC_W-1:0] pc,
    input  logic [1:0]      instr_len,
    input  logic [2:0]      page_hi,
    input  logic [DW-1:0]   op1,
    input  logic [DW-1:0]   op2,
    input  logic            taken,
    input  logic [DW-1:0]   acc,
    input  logic [PC_W-1:0] dptr,
    output logic [PC_W-1:0] seq_pc,
    output logic [PC_W-1:0] rel_pc,
    output logic [PC_W-1:0] page_pc,
    output logic [PC_W-1:0] page_ret,
    output logic [PC_W-1:0] long_pc,
    output logic [PC_W-1:0] long_ret,
    output logic [PC_W-1:0] idx_pc,
    output logic [PC_W-1:0] tbl_addr
);
    localparam int PAGE_BITS = 3 + DW;

    logic [DW-1:0]   rel_off;
    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] acc_ext;

    always_comb begin
        seq_pc   = pc + PC_W'(instr_len);
        rel_off  = (instr_len == 2'd3) ? op2 : op1;
        off_ext  = {{(PC_W-DW){rel_off[DW-1]}}, rel_off};
        acc_ext  = {{(PC_W-DW){1'b0}}, acc};
        rel_pc   = taken ? (seq_pc + off_ext) : seq_pc;
        page_ret = pc + PC_W'(2);
        page_pc  = {page_ret[PC_W-1:PAGE_BITS], page_hi, op1};
        long_ret = pc + PC_W'(3);
        long_pc  = {op1, op2};
        idx_pc   = dptr + acc_ext;
        tbl_addr = seq_pc + acc_ext;
    end
endmodule

// File: rtl/pcs_stack_port.sv
module pcs_stack_port
    import pcs_pkg::*;
#(
    parameter int PC_W = 16,
    parameter int SP_W = 8,
    parameter int DW   = 8
) (
    input  seq_state_e      state,
    input  logic [SP_W-1:0] sp,
    input  logic [PC_W-1:0] ret_addr,
    output logic            ram_we,
    output logic            ram_re,
    output logic [SP_W-1:0] ram_addr,
    output logic [DW-1:0]   ram_wdata
);
    always_comb begin
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_addr  = sp;
        ram_wdata = '0;
        unique case (state)
            ST_PUSH_LO: begin
                ram_we    = 1'b1;
                ram_addr  = sp + SP_W'(1);
                ram_wdata = ret_addr[DW-1:0];
            end
            ST_PUSH_HI: begin
                ram_we    = 1'b1;
                ram_addr  = sp + SP_W'(1);
                ram_wdata = ret_addr[PC_W-1:DW];
            end
            ST_POP_HI, ST_POP_LO: begin
                ram_re    = 1'b1;
                ram_addr  = sp;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
    import pcs_pkg::*;
#(
    parameter int          PC_W     = 16,
    parameter int          SP_W     = 8,
    parameter int          DW       = 8,
    parameter logic [7:0]  SP_RESET = 8'h07
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op_kind,
    input  logic [1:0]      instr_len,
    input  logic [7:0]      opcode,
    input  logic [7:0]      op1,
    input  logic [7:0]      op2,
    input  logic            taken,
    input  logic [7:0]      acc,
    input  logic [15:0]     dptr,
    input  logic [7:0]      ram_rdata,
    output logic [15:0]     pc,
    output logic [7:0]      sp,
    output logic            busy,
    output logic            done,
    output logic            irq_done,
    output logic [15:0]     tbl_addr,
    output logic            ram_we,
    output logic            ram_re,
    output logic [7:0]      ram_addr,
    output logic [7:0]      ram_wdata
);
    localparam int HALF = PC_W / 2;

    seq_state_e      st_q, st_d;
    op_kind_e        kind;
    logic            page_call;
    logic [PC_W-1:0] pc_q, ret_q, tgt_q;
    logic [SP_W-1:0] sp_q;
    logic            reti_q, done_q, irq_q;

    logic [PC_W-1:0] seq_pc, rel_pc, page_pc, page_ret;
    logic [PC_W-1:0] long_pc, long_ret, idx_pc;

    assign kind      = op_kind_e'(op_kind);
    assign page_call = (opcode[4:0] == PAGE_CALL_LOW5);

    pcs_target_calc #(.PC_W(PC_W), .DW(DW)) calc_i (
        .pc       (pc_q),
        .instr_len(instr_len),
        .page_hi  (opcode[7:5]),
        .op1      (op1),
        .op2      (op2),
        .taken    (taken),
        .acc      (acc),
        .dptr     (dptr),
        .seq_pc   (seq_pc),
        .rel_pc   (rel_pc),
        .page_pc  (page_pc),
        .page_ret (page_ret),
        .long_pc  (long_pc),
        .long_ret (long_ret),
        .idx_pc   (idx_pc),
        .tbl_addr (tbl_addr)
    );

    pcs_stack_port #(.PC_W(PC_W), .SP_W(SP_W), .DW(DW)) port_i (
        .state    (st_q),
        .sp       (sp_q),
        .ret_addr (ret_q),
        .ram_we   (ram_we),
        .ram_re   (ram_re),
        .ram_addr (ram_addr),
        .ram_wdata(ram_wdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    case (kind)
                        OP_PAGE:         if (page_call) st_d = ST_PUSH_LO;
                        OP_LCALL:        st_d = ST_PUSH_LO;
                        OP_RET, OP_RETI: st_d = ST_POP_HI;
                        default:         st_d = ST_IDLE;
                    endcase
                end
            end
            ST_PUSH_LO: st_d = ST_PUSH_HI;
            ST_PUSH_HI: st_d = ST_IDLE;
            ST_POP_HI:  st_d = ST_POP_LO;
            ST_POP_LO:  st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            sp_q   <= SP_RESET;
            ret_q  <= '0;
            tgt_q  <= '0;
            reti_q <= 1'b0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            irq_q  <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        case (kind)
                            OP_SEQ: begin
                                pc_q <= seq_pc;  done_q <= 1'b1;
                            end
                            OP_REL: begin
                                pc_q <= rel_pc;  done_q <= 1'b1;
                            end
                            OP_PAGE: begin
                                if (page_call) begin
                                    ret_q <= page_ret;
                                    tgt_q <= page_pc;
                                end else begin
                                    pc_q   <= page_pc;
                                    done_q <= 1'b1;
                                end
                            end
                            OP_LJMP: begin
                                pc_q <= long_pc; done_q <= 1'b1;
                            end
                            OP_LCALL: begin
                                ret_q <= long_ret;
                                tgt_q <= long_pc;
                            end
                            OP_IDX: begin
                                pc_q <= idx_pc;  done_q <= 1'b1;
                            end
                            OP_RET, OP_RETI: reti_q <= (kind == OP_RETI);
                            default: ;
                        endcase
                    end
                end
                ST_PUSH_LO: sp_q <= sp_q + SP_W'(1);
                ST_PUSH_HI: begin
                    sp_q   <= sp_q + SP_W'(1);
                    pc_q   <= tgt_q;
                    done_q <= 1'b1;
                end
                ST_POP_HI: begin
                    ret_q[PC_W-1:HALF] <= ram_rdata;
                    sp_q <= sp_q - SP_W'(1);
                end
                ST_POP_LO: begin
                    pc_q   <= {ret_q[PC_W-1:HALF], ram_rdata};
                    sp_q   <= sp_q - SP_W'(1);
                    done_q <= 1'b1;
                    irq_q  <= reti_q;
                end
                default: ;
            endcase
        end
    end

    assign pc       = pc_q;
    assign sp       = sp_q;
    assign busy     = (st_q != ST_IDLE);
    assign done     = done_q;
    assign irq_done = irq_q;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
    parameter int SP_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            irq_done,
    input logic [SP_W-1:0] sp,
    input logic            ram_we,
    input logic            ram_re,
    input logic [SP_W-1:0] ram_addr
);
    // R1: stack pointer holds still while idle
    a_r1_sp_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(sp));

    // R4: pushes come in pairs at consecutive addresses
    a_r4_push_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we) |=> ram_we && (ram_addr == $past(ram_addr) + SP_W'(1)));

    // R4: each write raises the stack pointer
    a_r4_push_sp_up: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> sp == $past(sp) + SP_W'(1));

    // R4: read and write never overlap
    a_r4_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    // R7: each read lowers the stack pointer
    a_r7_pop_sp_down: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> sp == $past(sp) - SP_W'(1));

    // R8: interrupt completion only with done, one cycle long
    a_r8_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> done);
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);

    // R10: completion is reported only once the sequencer is idle again
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind pc_seq_unit pcs_checker #(.SP_W(8)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .irq_done (irq_done),
    .sp       (sp),
    .ram_we   (ram_we),
    .ram_re   (ram_re),
    .ram_addr (ram_addr)
);

// File: tb/pc_seq_unit_tb_top.sv
`timescale 1ns/1ps
module pc_seq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [1:0]  instr_len = 2'd1;
    logic [7:0]  opcode = '0, op1 = '0, op2 = '0, acc = '0;
    logic        taken = 1'b0;
    logic [15:0] dptr = '0;
    logic [7:0]  ram_rdata;
    logic [15:0] pc, tbl_addr;
    logic [7:0]  sp, ram_addr, ram_wdata;
    logic        busy, done, irq_done, ram_we, ram_re;

    logic [7:0] mem [256];

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [15:0] pc;
        logic [7:0]  sp;
        logic        irq;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    pc_seq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .instr_len(instr_len), .opcode(opcode), .op1(op1), .op2(op2),
        .taken(taken), .acc(acc), .dptr(dptr), .ram_rdata(ram_rdata),
        .pc(pc), .sp(sp), .busy(busy), .done(done), .irq_done(irq_done),
        .tbl_addr(tbl_addr), .ram_we(ram_we), .ram_re(ram_re),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(pc == e.pc, e.req, "pc", pc, e.pc);
                chk(sp == e.sp, e.req, "sp", sp, e.sp);
                chk(irq_done == e.irq, e.req, "irq_done", irq_done, e.irq);
            end
        end
    end

    // driver: issue one operation and wait for its completion
    task automatic run_op(input logic [2:0] k, input logic [1:0] len,
                          input logic [7:0] opc, input logic [7:0] b1,
                          input logic [7:0] b2, input logic tk,
                          input logic [15:0] e_pc, input logic [7:0] e_sp,
                          input logic e_irq, input string req);
        exp_t e;
        @(negedge clk);
        op_kind = k; instr_len = len; opcode = opc; op1 = b1; op2 = b2; taken = tk;
        start = 1'b1;
        e.pc = e_pc; e.sp = e_sp; e.irq = e_irq; e.req = req;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R1", "watchdog", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        exp_t e;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pc == 16'h0000, "R1", "reset pc", pc, 16'h0000);
        chk(sp == 8'h07, "R1", "reset sp", sp, 8'h07);
        chk(!busy && !done && !ram_we && !ram_re, "R1", "reset idle",
            {busy, done, ram_we, ram_re}, 0);

        // R5 long jump
        run_op(3'd3, 2'd3, 8'h02, 8'h01, 8'h23, 1'b0, 16'h0123, 8'h07, 1'b0, "R5");
        // R3 R4 page call at 0123h to 0345h
        run_op(3'd2, 2'd2, 8'h71, 8'h45, 8'h00, 1'b0, 16'h0345, 8'h09, 1'b0, "R3");
        chk(mem[8'h08] == 8'h25, "R4", "low return byte", mem[8'h08], 8'h25);
        chk(mem[8'h09] == 8'h01, "R4", "high return byte", mem[8'h09], 8'h01);
        // R2 relative taken forward, len 2
        run_op(3'd1, 2'd2, 8'h00, 8'h10, 8'h00, 1'b1, 16'h0357, 8'h09, 1'b0, "R2");
        // R2 relative taken backward, len 3 uses op2
        run_op(3'd1, 2'd3, 8'h00, 8'h7F, 8'h80, 1'b1, 16'h02DA, 8'h09, 1'b0, "R2");
        // R2 not taken
        run_op(3'd1, 2'd2, 8'h00, 8'h40, 8'h00, 1'b0, 16'h02DC, 8'h09, 1'b0, "R2");
        // R3 page jump across a 2K boundary
        run_op(3'd3, 2'd3, 8'h02, 8'h07, 8'hFE, 1'b0, 16'h07FE, 8'h09, 1'b0, "R5");
        run_op(3'd2, 2'd2, 8'h01, 8'h10, 8'h00, 1'b0, 16'h0810, 8'h09, 1'b0, "R3");
        // R5 long call
        run_op(3'd4, 2'd3, 8'h12, 8'h20, 8'h00, 1'b0, 16'h2000, 8'h0B, 1'b0, "R5");
        chk(mem[8'h0A] == 8'h13, "R5", "long call low byte", mem[8'h0A], 8'h13);
        chk(mem[8'h0B] == 8'h08, "R5", "long call high byte", mem[8'h0B], 8'h08);
        // R6 indexed
        dptr = 16'h1234; acc = 8'hF0;
        run_op(3'd5, 2'd1, 8'h73, 8'h00, 8'h00, 1'b0, 16'h1324, 8'h0B, 1'b0, "R6");
        // R9 table address
        @(negedge clk);
        instr_len = 2'd1; acc = 8'h00;
        #1 chk(tbl_addr == 16'h1325, "R9", "tbl index 0", tbl_addr, 16'h1325);
        acc = 8'hFF;
        #1 chk(tbl_addr == 16'h1424, "R9", "tbl index FF", tbl_addr, 16'h1424);
        acc = 8'h00;
        // R7 plain return
        run_op(3'd6, 2'd1, 8'h22, 8'h00, 8'h00, 1'b0, 16'h0813, 8'h09, 1'b0, "R7");
        // R8 interrupt return
        run_op(3'd7, 2'd1, 8'h32, 8'h00, 8'h00, 1'b0, 16'h0125, 8'h07, 1'b1, "R8");
        @(negedge clk);
        chk(irq_done == 1'b0, "R8", "irq pulse length", irq_done, 1'b0);

        // R10 start while busy is ignored
        @(negedge clk);
        op_kind = 3'd4; instr_len = 2'd3; op1 = 8'h40; op2 = 8'h00; start = 1'b1;
        e.pc = 16'h4000; e.sp = 8'h09; e.irq = 1'b0; e.req = "R10";
        sb.push_back(e);
        @(negedge clk);
        op_kind = 3'd3; op1 = 8'hFF; op2 = 8'hFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(pc == 16'h4000, "R10", "pc after ignored start", pc, 16'h4000);
        chk(sb.size() == 0, "R10", "pending items", sb.size(), 0);
        chk(mem[8'h08] == 8'h28, "R10", "pushed low byte", mem[8'h08], 8'h28);

        // R11 sequential advance
        run_op(3'd0, 2'd3, 8'h00, 8'h00, 8'h00, 1'b0, 16'h4003, 8'h09, 1'b0, "R11");
        repeat (2) @(negedge clk);
        chk(sp == 8'h09, "R1", "sp steady idle", sp, 8'h09);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule